// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Engine

This block moves packet bytes between a host processor and a controller through one 8-bit shift register. Pacing comes from three handshake lines held in a host-writable port B register: request (bit 3, driven by the engine), acknowledge (bit 4) and transaction-in-progress (bit 5, active low). A direction input chooses whether the host is sending bytes to the controller or reading reply bytes back. Bytes do not move on a clock. A transfer step happens only when a host write to port B changes the acknowledge or in-progress line.

In send direction, every qualifying port B write appends the current shift-register byte to a 16-entry collect buffer. When the transaction closes, a one-cycle packet strobe reports the byte count, and the controller side reads the bytes through a random-access read port. In receive direction, the controller first fills a reply buffer and commits it with a length. Each qualifying port B write then moves the next reply byte into the shift register. The request line rises after the final byte. Every step also schedules a shift-register interrupt pulse. The pulse comes after a fixed 300 µs delay, or in the cycle of the step when the port B direction register reads all ones.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, port B and the shift register read 0, and no interrupt pulse and no packet strobe are given.
- R2: With send direction selected and bit 5 of the written port B value at 0, a write that changes bit 4 or bit 5 relative to the stored port B value appends the shift-register byte at the next collect-buffer position and schedules an interrupt.
- R3: The collect buffer holds at most 16 bytes. A qualifying write that finds it full appends nothing and schedules no interrupt.
- R4: With receive direction selected, bit 5 written as 0 and reply bytes pending, a write that changes bit 4 or bit 5 loads the next reply byte into the shift register and schedules an interrupt. With no reply byte pending, the shift register stays unchanged and no interrupt is scheduled.
- R5: The step that delivers the last reply byte sets request bit 3 to 1.
- R6: When bit 5 is 1 in both the stored and the written value and bit 4 changes, bit 3 takes the new bit 4 value and an interrupt is scheduled.
- R7: A write that takes bit 5 from 0 to 1 ends the transaction. In the cycle after the write, a packet strobe carries the collected count, but only if the count is nonzero. The collect position returns to 0 and an interrupt is scheduled.
- R8: Whenever bit 5 is 1 and a write or reply load is evaluated while reply bytes are pending (except the R6 case), bit 3 is forced to 0.
- R9: Committing a reply packet restarts delivery at its first byte, re-evaluates the handshake with the stored port B value, and schedules an interrupt.
- R10: An interrupt scheduled while the direction register is not 0xFF pulses for one cycle exactly DELAY_CYC clock edges after the scheduling edge. If the direction register is 0xFF, it pulses in the cycle right after the scheduling edge.
- R11: Scheduling again while a delay is running restarts the full delay from the new scheduling edge.
- R12: A port B write that leaves bits 4 and 5 unchanged during an active transaction stores the value but appends nothing, loads nothing and schedules nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| portb_wr_i | input | 1 | Host write strobe for port B |
| portb_wdata_i | input | 8 | Value written to port B |
| portb_o | output | 8 | Stored port B value, including the engine-driven request bit |
| req_o | output | 1 | Request line (port B bit 3) |
| send_dir_i | input | 1 | 1: host sends to controller; 0: controller replies to host |
| dirb_i | input | 8 | Port B direction register; 0xFF gives immediate interrupts |
| sr_wr_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Value written to the shift register |
| sr_o | output | 8 | Shift-register contents |
| reply_wr_i | input | 1 | Reply buffer byte write strobe |
| reply_waddr_i | input | 4 | Reply buffer write address |
| reply_wdata_i | input | 8 | Reply buffer write data |
| reply_load_i | input | 1 | Commit a reply packet of reply_len_i bytes (takes priority over a port B write in the same cycle) |
| reply_len_i | input | 5 | Reply packet length, clamped to the buffer depth |
| sr_irq_o | output | 1 | One-cycle shift-register interrupt pulse |
| pkt_done_o | output | 1 | One-cycle packet-complete strobe |
| pkt_len_o | output | 5 | Byte count of the completed packet |
| rx_raddr_i | input | 4 | Collect buffer read address |
| rx_rdata_o | output | 8 | Collect buffer read data (combinational) |

## Verification
A port B write that the host presents in one cycle is taken at the next rising edge. The new port B value, shift-register byte, collect-buffer slot and packet strobe all appear right after that same edge. The bench therefore drives each write for one cycle and checks these results at the falling edge that follows. An immediate interrupt also appears at that falling edge. A delayed interrupt is counted at each falling edge after the scheduling edge, and the count must equal DELAY_CYC exactly. Any restart of the delay is measured from the later scheduling edge. Cases where nothing should happen are watched for several falling edges, so that a stray interrupt or shift-register load cannot be missed.

// File: rtl/hs_xfer_pkg.sv
`timescale 1ns/1ps
package hs_xfer_pkg;
  localparam int unsigned REQ_BIT = 3;
  localparam int unsigned ACK_BIT = 4;
  localparam int unsigned TIP_BIT = 5;
  localparam logic [7:0] LINE_MASK = 8'h30;

  typedef struct packed {
    logic       append;
    logic       take;
    logic       close;
    logic       sched;
    logic [7:0] b_next;
  } hs_act_t;
endpackage

// File: rtl/hs_decide.sv
`timescale 1ns/1ps
module hs_decide
  import hs_xfer_pkg::*;
(
  input  logic       eval_i,
  input  logic [7:0] b_new_i,
  input  logic [7:0] b_old_i,
  input  logic       send_i,
  input  logic       full_i,
  input  logic       pending_i,
  input  logic       last_i,
  output hs_act_t    act_o
);
  logic lines_moved;

  always_comb begin
    lines_moved  = |((b_new_i ^ b_old_i) & LINE_MASK);
    act_o        = '0;
    act_o.b_next = b_new_i;
    if (eval_i) begin
      if (!b_new_i[TIP_BIT]) begin
        if (send_i) begin
          if (lines_moved && !full_i) begin
            act_o.append = 1'b1;
            act_o.sched  = 1'b1;
          end
        end else if (pending_i && lines_moved) begin
          act_o.take  = 1'b1;
          act_o.sched = 1'b1;
          if (last_i) act_o.b_next[REQ_BIT] = 1'b1;
        end
      end else if (b_old_i[TIP_BIT] && (b_new_i[ACK_BIT] != b_old_i[ACK_BIT])) begin
        // idle acknowledge toggle is mirrored onto request
        act_o.b_next[REQ_BIT] = b_new_i[ACK_BIT];
        act_o.sched           = 1'b1;
      end else begin
        if (!b_old_i[TIP_BIT]) begin
          act_o.close = 1'b1;
          act_o.sched = 1'b1;
        end
        if (pending_i) act_o.b_next[REQ_BIT] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_collect_buf.sv
`timescale 1ns/1ps
module hs_collect_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          clear_i,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  slot_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q[e] <= '0;
      else if (push_i && (cnt_q == CW'(e)))      slot_q[e] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + CW'(1);
  end

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/hs_reply_buf.sv
`timescale 1ns/1ps
module hs_reply_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          take_i,
  output logic [W-1:0]  byte_o,
  output logic          pending_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] len_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] idx_q, len_q, len_clamp;

  assign len_clamp = (len_i > CW'(DEPTH)) ? CW'(DEPTH) : len_i;

  for (genvar e = 0; e < DEPTH; e++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[e] <= '0;
      else if (wr_i && (waddr_i == AW'(e))) mem_q[e] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      len_q <= len_clamp;
    end else if (take_i && pending_o) begin
      idx_q <= idx_q + CW'(1);
    end
  end

  assign byte_o    = mem_q[idx_q[AW-1:0]];
  assign pending_o = (idx_q < len_q);
  assign last_o    = ((idx_q + CW'(1)) >= len_q);
  assign idx_o     = idx_q;
  assign len_o     = len_q;
endmodule

// File: rtl/hs_sr_delay.sv
`timescale 1ns/1ps
module hs_sr_delay #(
  parameter int unsigned DELAY_CYC = 60000,
  localparam int unsigned CW       = $clog2(DELAY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sched_i,
  input  logic now_i,
  output logic irq_o
);
  logic [CW-1:0] cnt_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (sched_i) begin
        if (now_i) begin
          irq_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= CW'(DELAY_CYC);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) irq_q <= 1'b1;
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hs_xfer_engine.sv
`timescale 1ns/1ps
module hs_xfer_engine
  import hs_xfer_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned DELAY_US = 300,
  parameter int unsigned DEPTH    = 16,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned CW      = $clog2(DEPTH + 1),
  localparam int unsigned DLY_RAW = (CLK_HZ / 1000) * DELAY_US / 1000,
  localparam int unsigned DELAY_CYC = (DLY_RAW == 0) ? 1 : DLY_RAW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          portb_wr_i,
  input  logic [7:0]    portb_wdata_i,
  output logic [7:0]    portb_o,
  output logic          req_o,
  input  logic          send_dir_i,
  input  logic [7:0]    dirb_i,
  input  logic          sr_wr_i,
  input  logic [7:0]    sr_wdata_i,
  output logic [7:0]    sr_o,
  input  logic          reply_wr_i,
  input  logic [AW-1:0] reply_waddr_i,
  input  logic [7:0]    reply_wdata_i,
  input  logic          reply_load_i,
  input  logic [CW-1:0] reply_len_i,
  output logic          sr_irq_o,
  output logic          pkt_done_o,
  output logic [CW-1:0] pkt_len_o,
  input  logic [AW-1:0] rx_raddr_i,
  output logic [7:0]    rx_rdata_o
);
  logic [7:0]    portb_q, sr_q, rep_byte, b_new;
  logic [CW-1:0] out_cnt, rep_idx, rep_len, pkt_len_q;
  logic          out_full, rep_pending, rep_last, eval, pending_eval, pkt_done_q;
  hs_act_t       act;

  assign eval         = portb_wr_i | reply_load_i;
  // a reply commit re-evaluates against the unchanged stored value
  assign b_new        = reply_load_i ? portb_q : portb_wdata_i;
  assign pending_eval = reply_load_i ? (reply_len_i != '0) : rep_pending;

  hs_decide u_decide (
    .eval_i    (eval),
    .b_new_i   (b_new),
    .b_old_i   (portb_q),
    .send_i    (send_dir_i),
    .full_i    (out_full),
    .pending_i (pending_eval),
    .last_i    (rep_last),
    .act_o     (act)
  );

  hs_collect_buf #(.DEPTH(DEPTH), .W(8)) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (act.append),
    .data_i  (sr_q),
    .clear_i (act.close),
    .cnt_o   (out_cnt),
    .full_o  (out_full),
    .raddr_i (rx_raddr_i),
    .rdata_o (rx_rdata_o)
  );

  hs_reply_buf #(.DEPTH(DEPTH), .W(8)) u_reply (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reply_wr_i),
    .waddr_i   (reply_waddr_i),
    .wdata_i   (reply_wdata_i),
    .load_i    (reply_load_i),
    .len_i     (reply_len_i),
    .take_i    (act.take),
    .byte_o    (rep_byte),
    .pending_o (rep_pending),
    .last_o    (rep_last),
    .idx_o     (rep_idx),
    .len_o     (rep_len)
  );

  hs_sr_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sched_i (act.sched | reply_load_i),
    .now_i   (dirb_i == 8'hFF),
    .irq_o   (sr_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      portb_q    <= '0;
      sr_q       <= '0;
      pkt_done_q <= 1'b0;
      pkt_len_q  <= '0;
    end else begin
      if (eval) portb_q <= act.b_next;
      if (act.take)     sr_q <= rep_byte;
      else if (sr_wr_i) sr_q <= sr_wdata_i;
      pkt_done_q <= act.close && (out_cnt != '0);
      if (act.close && (out_cnt != '0)) pkt_len_q <= out_cnt;
    end
  end

  assign portb_o    = portb_q;
  assign req_o      = portb_q[REQ_BIT];
  assign sr_o       = sr_q;
  assign pkt_done_o = pkt_done_q;
  assign pkt_len_o  = pkt_len_q;
endmodule

// File: rtl/hs_xfer_chk.sv
`timescale 1ns/1ps
module hs_xfer_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          portb_wr_i,
  input logic          reply_load_i,
  input logic          sr_wr_i,
  input logic [7:0]    dirb_i,
  input logic [7:0]    portb_o,
  input logic [7:0]    sr_o,
  input logic          sr_irq_o,
  input logic          pkt_done_o,
  input logic [CW-1:0] pkt_len_o,
  input logic [CW-1:0] out_cnt,
  input logic [CW-1:0] rep_idx,
  input logic [CW-1:0] rep_len
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt <= CW'(DEPTH)); // R3
  AST_REPLY_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_idx <= rep_len); // R4
  AST_SR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!portb_wr_i && !sr_wr_i) |=> $stable(sr_o)); // R4
  AST_PORTB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!portb_wr_i && !reply_load_i) |=> $stable(portb_o)); // R12
  AST_PKT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> (pkt_len_o != '0) && portb_o[5]); // R7
  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_load_i |=> (rep_idx == '0)); // R9
  AST_IMM_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_load_i && dirb_i == 8'hFF) |=> sr_irq_o); // R10
endmodule

bind hs_xfer_engine hs_xfer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .portb_wr_i   (portb_wr_i),
  .reply_load_i (reply_load_i),
  .sr_wr_i      (sr_wr_i),
  .dirb_i       (dirb_i),
  .portb_o      (portb_o),
  .sr_o         (sr_o),
  .sr_irq_o     (sr_irq_o),
  .pkt_done_o   (pkt_done_o),
  .pkt_len_o    (pkt_len_o),
  .out_cnt      (out_cnt),
  .rep_idx      (rep_idx),
  .rep_len      (rep_len)
);

// File: tb/hs_xfer_engine_test.sv
`timescale 1ns/1ps
module hs_xfer_engine_test;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int unsigned DLY_US = 300;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned AW     = 4;
  localparam int unsigned CW     = 5;
  localparam int EXP_DLY = (CLK_HZ / 1000) * DLY_US / 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic portb_wr_i = 1'b0;
  logic [7:0] portb_wdata_i = '0;
  logic [7:0] portb_o;
  logic req_o;
  logic send_dir_i = 1'b1;
  logic [7:0] dirb_i = 8'hFF;
  logic sr_wr_i = 1'b0;
  logic [7:0] sr_wdata_i = '0;
  logic [7:0] sr_o;
  logic reply_wr_i = 1'b0;
  logic [AW-1:0] reply_waddr_i = '0;
  logic [7:0] reply_wdata_i = '0;
  logic reply_load_i = 1'b0;
  logic [CW-1:0] reply_len_i = '0;
  logic sr_irq_o, pkt_done_o;
  logic [CW-1:0] pkt_len_o;
  logic [AW-1:0] rx_raddr_i = '0;
  logic [7:0] rx_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic ack = 1'b0;

  always #2.5 clk = ~clk;

  hs_xfer_engine #(.CLK_HZ(CLK_HZ), .DELAY_US(DLY_US), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .portb_wr_i(portb_wr_i), .portb_wdata_i(portb_wdata_i),
    .portb_o(portb_o), .req_o(req_o), .send_dir_i(send_dir_i), .dirb_i(dirb_i),
    .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i), .sr_o(sr_o), .reply_wr_i(reply_wr_i),
    .reply_waddr_i(reply_waddr_i), .reply_wdata_i(reply_wdata_i), .reply_load_i(reply_load_i),
    .reply_len_i(reply_len_i), .sr_irq_o(sr_irq_o), .pkt_done_o(pkt_done_o),
    .pkt_len_o(pkt_len_o), .rx_raddr_i(rx_raddr_i), .rx_rdata_o(rx_rdata_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic tip, input logic a, input logic rq);
    return {2'b00, tip, a, rq, 3'b000};
  endfunction

  task automatic wr_b(input logic [7:0] v);
    portb_wdata_i = v; portb_wr_i = 1'b1;
    @(negedge clk); portb_wr_i = 1'b0;
  endtask

  task automatic wr_sr(input logic [7:0] v);
    sr_wdata_i = v; sr_wr_i = 1'b1;
    @(negedge clk); sr_wr_i = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (sr_irq_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic wait_irq(output int c);
    c = 0;
    while (!sr_irq_o && c < 200) begin @(negedge clk); c++; end
    if (!sr_irq_o) c = -1;
  endtask

  function automatic logic [7:0] sval(input int i);
    return 8'(8'hA0 + i * 7);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    int c;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(portb_o == 8'h00, "R1 portb", portb_o, 0);
    chk(sr_o == 8'h00, "R1 sr", sr_o, 0);
    chk(!sr_irq_o && !pkt_done_o, "R1 pulses", {sr_irq_o, pkt_done_o}, 0);

    // R2 send sweep filling the collect buffer
    send_dir_i = 1'b1; dirb_i = 8'hFF;
    for (int i = 0; i < DEPTH; i++) begin
      wr_sr(sval(i));
      ack = ~ack;
      wr_b(mk(1'b0, ack, 1'b0));
      chk(sr_irq_o == 1'b1, "R2 irq", sr_irq_o, 1);
      rx_raddr_i = AW'(i); #1;
      chk(rx_rdata_o == sval(i), "R2 byte", rx_rdata_o, sval(i));
    end
    // R12 non-line bit change in active transaction
    v = mk(1'b0, ack, 1'b0) | 8'h01;
    wr_b(v);
    chk(portb_o == v, "R12 stored", portb_o, v);
    quiet(4, "R12 no irq");
    // R3 full buffer
    wr_sr(8'h55);
    ack = ~ack;
    wr_b(mk(1'b0, ack, 1'b0));
    quiet(4, "R3 no irq when full");
    // R7 close
    wr_b(mk(1'b1, ack, 1'b0));
    chk(pkt_done_o == 1'b1, "R7 strobe", pkt_done_o, 1);
    chk(pkt_len_o == CW'(DEPTH), "R7 count", pkt_len_o, DEPTH);
    chk(sr_irq_o == 1'b1, "R7 irq", sr_irq_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rx_raddr_i = AW'(i); #1;
      chk(rx_rdata_o == sval(i), "R3 contents kept", rx_rdata_o, sval(i));
    end
    @(negedge clk);
    chk(pkt_done_o == 1'b0, "R7 single pulse", pkt_done_o, 0);
    // R6 idle acknowledge mirror, both polarities
    for (int k = 0; k < 2; k++) begin
      ack = ~ack;
      wr_b(mk(1'b1, ack, ~ack));
      chk(req_o == ack, "R6 req", req_o, ack);
      chk(sr_irq_o == 1'b1, "R6 irq", sr_irq_o, 1);
    end

    // R4 R5 R8 R9 receive sweep over reply lengths
    send_dir_i = 1'b0;
    for (int n = 1; n <= 4; n++) begin
      if (!ack) begin
        ack = 1'b1;
        wr_b(mk(1'b1, ack, 1'b0));
      end
      chk(req_o == 1'b1, "R6 req high before load", req_o, 1);
      for (int j = 0; j < n; j++) begin
        reply_waddr_i = AW'(j); reply_wdata_i = 8'(8'h30 + n * 16 + j); reply_wr_i = 1'b1;
        @(negedge clk);
      end
      reply_wr_i = 1'b0;
      reply_len_i = CW'(n); reply_load_i = 1'b1;
      @(negedge clk); reply_load_i = 1'b0;
      chk(req_o == 1'b0, "R8 req cleared", req_o, 0);
      chk(sr_irq_o == 1'b1, "R9 irq", sr_irq_o, 1);
      wr_b(mk(1'b0, ack, req_o));
      chk(sr_o == 8'(8'h30 + n * 16), "R9 first byte", sr_o, 8'h30 + n * 16);
      chk(sr_irq_o == 1'b1, "R4 irq", sr_irq_o, 1);
      chk(req_o == (n == 1), "R5 req", req_o, n == 1);
      for (int j = 1; j < n; j++) begin
        ack = ~ack;
        wr_b(mk(1'b0, ack, req_o));
        chk(sr_o == 8'(8'h30 + n * 16 + j), "R4 byte", sr_o, 8'h30 + n * 16 + j);
        chk(req_o == (j == n - 1), "R5 req", req_o, j == n - 1);
      end
      v = sr_o;
      ack = ~ack;
      wr_b(mk(1'b0, ack, req_o));
      chk(sr_o == v, "R4 none pending", sr_o, v);
      quiet(3, "R4 no irq none pending");
      wr_b(mk(1'b1, ack, req_o));
      chk(pkt_done_o == 1'b0, "R7 no strobe empty", pkt_done_o, 0);
      chk(sr_irq_o == 1'b1, "R7 irq empty", sr_irq_o, 1);
    end

    // R10 delayed interrupt
    dirb_i = 8'h00;
    @(negedge clk);
    ack = ~ack;
    wr_b(mk(1'b1, ack, 1'b0));
    wait_irq(c);
    chk(c == EXP_DLY, "R10 delay", c, EXP_DLY);
    @(negedge clk);
    chk(sr_irq_o == 1'b0, "R10 pulse width", sr_irq_o, 0);
    // R11 restart
    ack = ~ack;
    wr_b(mk(1'b1, ack, 1'b0));
    quiet(10, "R11 no early irq");
    ack = ~ack;
    wr_b(mk(1'b1, ack, 1'b0));
    wait_irq(c);
    chk(c == EXP_DLY, "R11 restart delay", c, EXP_DLY);

    summary();
  end
endmodule